// File: doc/BRIEF.md
# Checkpoint and Replay Sequencer

This controller orders the save and restore phases of a group of agents so that a run can be rolled back and repeated cycle for cycle. It keeps a domain-clock counter of its own. In normal running it starts a checkpoint when that counter reaches the configured interval or when any of the event logs reports that it is nearly full. A checkpoint has two barriers. First every agent is asked to prepare and must answer ready. Then every agent is told to save and must answer done. A one-cycle counter-reset pulse closes the checkpoint, and normal running resumes from count zero.

A replay request latches the present domain count as a stop marker and isolates I/O. It then asks every agent to restore its state and waits for all of them to answer. Next it hands the memory restore to the memory log through a request/done handshake and pulses the counter reset. Replay runs until the counter equals the stop marker, and the block then goes back to normal mode with I/O reconnected. A replay request that comes in while a checkpoint is running is held and acted on once the checkpoint has finished. If any barrier or the memory restore takes too long, the block locks into a fault mode, and only a reset clears it.

All pins are plain control levels; there is no data stream. Each agent handshake is level-based. A request stays high until the agent's acknowledge has been sampled while that request was high, and it then drops. The memory restore request likewise stays high until the done input is sampled high.

Top module: `ckpt_replay_ctrl`

## Requirements
- R1: During and after reset the mode is normal (code 0) and all agent requests, `agt_cmd` (code 0), `ctr_reset`, `io_isolate` and `mem_restore_req` are low. `dom_count` is 0 in reset and counts up by one each clock after release.
- R2: In normal mode a checkpoint starts one clock after any `log_near_full` bit is high or after `dom_count` reaches `INTERVAL_MAX`. Mode becomes checkpoint (code 1). For the interval case, the first checkpoint-mode cycle shows `dom_count` equal to `INTERVAL_MAX`+1.
- R3: The first checkpoint phase drives `agt_cmd` = 1 (prepare). A request is raised to every agent that has not yet answered in this phase.
- R4: The save phase (`agt_cmd` = 2) starts only after every agent has answered the prepare phase. It completes only after every agent has answered the save phase.
- R5: After all save answers, `ctr_reset` is high for exactly one clock. The next cycle shows `dom_count` = 0 and normal mode.
- R6: A replay request in normal mode with no checkpoint trigger moves to replay mode (code 2) on the next clock. It stores the current `dom_count` as the stop marker and issues the restore phase (`agt_cmd` = 3) to all agents.
- R7: `mem_restore_req` is raised only after every agent has answered the restore phase. It is held until `mem_restore_done` is seen, and `ctr_reset` then pulses for one clock.
- R8: `io_isolate` is high throughout replay. After the replay reset, replay runs for stop marker + 1 clocks. Normal mode then returns with `io_isolate` low and `dom_count` = stop marker + 1.
- R9: Each phase clears its collected answers on entry. An answer given in an earlier phase does not count toward a later one.
- R10: A barrier or memory-restore wait that lasts `WAIT_LIMIT`+1 clocks without completing moves to fault mode (code 3). Fault mode drops all agent requests and keeps the fault until reset.
- R11: A replay request during a checkpoint is held. Replay starts one clock after the checkpoint returns to normal mode, with stop marker 0.
- R12: During replay, `log_near_full` and `replay_req` have no effect: the replay length is unchanged and normal mode stays in place afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| log_near_full | input | N_LOGS | Near-full flags from the event logs |
| replay_req | input | 1 | Request to roll back and replay |
| agt_req | output | N_AGENTS | Per-agent request, high until that agent answers |
| agt_cmd | output | 2 | Broadcast phase command: 0 none, 1 prepare, 2 save, 3 restore |
| agt_ack | input | N_AGENTS | Per-agent answer |
| mem_restore_req | output | 1 | Memory restore request to the memory log |
| mem_restore_done | input | 1 | Memory restore finished |
| ctr_reset | output | 1 | One-cycle global domain-counter reset |
| io_isolate | output | 1 | I/O disconnected during replay |
| mode | output | 2 | 0 normal, 1 checkpoint, 2 replay, 3 fault |
| dom_count | output | CNT_W | Domain-clock count |

## Verification
The sequence is driven by each log flag on its own, by all flags together, by the interval timer and by replay requests. Agent answer delays are skewed so that the last answer comes from different agents in turn. This shows whether a barrier truly waits for its slowest member rather than its first or a fixed one. Replays begin at different counts, so an exact replay length of stop marker + 1 separates a correct marker capture from an off-by-one. An agent that answers the prepare phase but not the save phase separates a per-phase answer mask from one that carries over. A replay request during a checkpoint, and triggers during replay, show that requests are held or ignored at the right times.

// File: rtl/ckrp_pkg.sv
package ckrp_pkg;

  typedef enum logic [3:0] {
    ST_RUN,
    ST_CK_PREP,
    ST_CK_SAVE,
    ST_CK_RST,
    ST_RP_INIT,
    ST_RP_MEM,
    ST_RP_RST,
    ST_REPLAY,
    ST_FAULT
  } ctl_state_e;

  localparam logic [1:0] CMD_NONE    = 2'd0;
  localparam logic [1:0] CMD_PREP    = 2'd1;
  localparam logic [1:0] CMD_SAVE    = 2'd2;
  localparam logic [1:0] CMD_RESTORE = 2'd3;

  localparam logic [1:0] MODE_NORMAL = 2'd0;
  localparam logic [1:0] MODE_CKPT   = 2'd1;
  localparam logic [1:0] MODE_REPLAY = 2'd2;
  localparam logic [1:0] MODE_FAULT  = 2'd3;

endpackage

// File: rtl/ack_gather.sv
module ack_gather #(
  parameter int N_AGENTS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                arm,
  input  logic [N_AGENTS-1:0] ack,
  output logic [N_AGENTS-1:0] req,
  output logic                all_in
);

  logic [N_AGENTS-1:0] got_q;

  for (genvar i = 0; i < N_AGENTS; i++) begin : g_agent
    always_ff @(posedge clk) begin
      if (!rst_n)                      got_q[i] <= 1'b0;
      else if (clr)                    got_q[i] <= 1'b0;
      else if (arm && ack[i])          got_q[i] <= 1'b1;
    end

    assign req[i] = arm & ~got_q[i];

    // an answer, once collected, is only dropped when a new phase begins
    p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (got_q[i] && !clr) |=> got_q[i]);
  end

  assign all_in = &got_q;

endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
  parameter int WAIT_LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);

  localparam int TW = $clog2(WAIT_LIMIT + 1);
  localparam logic [TW-1:0] LIM = TW'(WAIT_LIMIT);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (restart)               cnt_q <= '0;
    else if (run && cnt_q != LIM)   cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q == LIM);

  // the count never leaves the range it was sized for
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);

endmodule

// File: rtl/dom_counter.sv
module dom_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zero,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (zero)  count <= '0;
    else            count <= count + 1'b1;
  end

endmodule

// File: rtl/ckpt_replay_ctrl.sv
module ckpt_replay_ctrl
  import ckrp_pkg::*;
#(
  parameter int N_AGENTS     = 4,
  parameter int N_LOGS       = 3,
  parameter int CNT_W        = 32,
  parameter int INTERVAL_MAX = 1000000,
  parameter int WAIT_LIMIT   = 1024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_LOGS-1:0]   log_near_full,
  input  logic                replay_req,
  output logic [N_AGENTS-1:0] agt_req,
  output logic [1:0]          agt_cmd,
  input  logic [N_AGENTS-1:0] agt_ack,
  output logic                mem_restore_req,
  input  logic                mem_restore_done,
  output logic                ctr_reset,
  output logic                io_isolate,
  output logic [1:0]          mode,
  output logic [CNT_W-1:0]    dom_count
);

  localparam logic [CNT_W-1:0] INTERVAL_CMP = CNT_W'(INTERVAL_MAX);

  ctl_state_e       state_q, state_d;
  logic [CNT_W-1:0] stop_q;
  logic             pend_q;
  logic             all_in;
  logic             tmo;
  logic             phase_start;
  logic             agent_wait;
  logic             any_wait;
  logic             ckpt_trig;
  logic             ckpt_busy;

  assign ckpt_trig   = (|log_near_full) || (dom_count >= INTERVAL_CMP);
  assign agent_wait  = (state_q == ST_CK_PREP) || (state_q == ST_CK_SAVE) ||
                       (state_q == ST_RP_INIT);
  assign any_wait    = agent_wait || (state_q == ST_RP_MEM);
  assign phase_start = (state_d != state_q);
  assign ckpt_busy   = (state_q == ST_CK_PREP) || (state_q == ST_CK_SAVE) ||
                       (state_q == ST_CK_RST);

  dom_counter #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .zero  (ctr_reset),
    .count (dom_count)
  );

  ack_gather #(.N_AGENTS(N_AGENTS)) u_acks (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (phase_start),
    .arm    (agent_wait),
    .ack    (agt_ack),
    .req    (agt_req),
    .all_in (all_in)
  );

  wait_timer #(.WAIT_LIMIT(WAIT_LIMIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (phase_start),
    .run     (any_wait),
    .expired (tmo)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (ckpt_trig)                    state_d = ST_CK_PREP;
        else if (pend_q || replay_req)    state_d = ST_RP_INIT;
      end
      ST_CK_PREP: begin
        if (all_in)                       state_d = ST_CK_SAVE;
        else if (tmo)                     state_d = ST_FAULT;
      end
      ST_CK_SAVE: begin
        if (all_in)                       state_d = ST_CK_RST;
        else if (tmo)                     state_d = ST_FAULT;
      end
      ST_CK_RST:                          state_d = ST_RUN;
      ST_RP_INIT: begin
        if (all_in)                       state_d = ST_RP_MEM;
        else if (tmo)                     state_d = ST_FAULT;
      end
      ST_RP_MEM: begin
        if (mem_restore_done)             state_d = ST_RP_RST;
        else if (tmo)                     state_d = ST_FAULT;
      end
      ST_RP_RST:                          state_d = ST_REPLAY;
      ST_REPLAY: begin
        if (dom_count == stop_q)          state_d = ST_RUN;
      end
      ST_FAULT:                           state_d = ST_FAULT;
      default:                            state_d = ST_FAULT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      stop_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RUN && state_d == ST_RP_INIT) begin
        stop_q <= dom_count;
        pend_q <= 1'b0;
      end else if (state_q == ST_RUN || ckpt_busy) begin
        pend_q <= pend_q | replay_req;
      end else begin
        pend_q <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_CK_PREP: agt_cmd = CMD_PREP;
      ST_CK_SAVE: agt_cmd = CMD_SAVE;
      ST_RP_INIT: agt_cmd = CMD_RESTORE;
      default:    agt_cmd = CMD_NONE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_RUN:                                  mode = MODE_NORMAL;
      ST_CK_PREP, ST_CK_SAVE, ST_CK_RST:       mode = MODE_CKPT;
      ST_RP_INIT, ST_RP_MEM, ST_RP_RST,
      ST_REPLAY:                               mode = MODE_REPLAY;
      default:                                 mode = MODE_FAULT;
    endcase
  end

  assign ctr_reset       = (state_q == ST_CK_RST) || (state_q == ST_RP_RST);
  assign mem_restore_req = (state_q == ST_RP_MEM);
  assign io_isolate      = (mode == MODE_REPLAY);

  // R5: the counter reset is a single-cycle pulse and zeroes the domain count
  p_reset_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_reset |=> !ctr_reset);
  p_count_zeroed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_reset |=> (dom_count == '0));

  // R3: a request is only raised with a phase command on the broadcast lines
  p_cmd_with_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (agt_req != '0) |-> (agt_cmd != CMD_NONE));

  // R4: the save phase follows a complete prepare barrier
  p_save_after_prep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (agt_cmd == CMD_SAVE && $past(agt_cmd) == CMD_PREP) |-> $past(all_in));

  // R7: memory restore only after every agent has restored
  p_mem_after_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_restore_req) |-> $past(all_in));

  // R8: replay ends when the counter meets the stop marker
  p_replay_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REPLAY && dom_count == stop_q) |=>
      (mode == MODE_NORMAL && !io_isolate));

  // R10: fault is sticky and silent toward the agents
  p_fault_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FAULT) |=> (mode == MODE_FAULT && agt_req == '0));
  p_timeout_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && agent_wait && !all_in) |=> (mode == MODE_FAULT));

endmodule

// File: tb/sim_ckpt_replay_ctrl.sv
module sim_ckpt_replay_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NA   = 4;
  localparam int NL   = 3;
  localparam int CW   = 16;
  localparam int IMAX = 300;
  localparam int WLIM = 40;
  localparam int WD_CYCLES = 150000;

  // [18:16] trigger kind (0..2 single log bit, 3 replay, 4 all logs), [15:0] 4-bit answer delay per agent
  localparam logic [18:0] VEC [6] = '{
    19'h00000, 19'h13210, 19'h20F00, 19'h31111, 19'h30A05, 19'h42222
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NL-1:0] log_near_full;
  logic          replay_req;
  logic [NA-1:0] agt_req;
  logic [1:0]    agt_cmd;
  logic [NA-1:0] agt_ack;
  logic          mem_restore_req;
  logic          mem_restore_done;
  logic          ctr_reset;
  logic          io_isolate;
  logic [1:0]    mode;
  logic [CW-1:0] dom_count;

  int checks = 0;
  int failures = 0;

  int dly [NA];
  int acnt [NA];
  logic [NA-1:0] sil_mask;
  logic [1:0]    sil_cmd;
  int  mcnt;
  int  n_rst, rp_cycles, order_err, stop_exp, save_cycles;
  bit  seen_ck, seen_prep, seen_save, seen_rest, seen_mem, rst_seen_rp;
  logic [NA-1:0] prep_ok, save_ok, rest_ok;
  logic [1:0]    last_mode;
  logic [CW-1:0] last_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  ckpt_replay_ctrl #(
    .N_AGENTS(NA), .N_LOGS(NL), .CNT_W(CW), .INTERVAL_MAX(IMAX), .WAIT_LIMIT(WLIM)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .log_near_full(log_near_full), .replay_req(replay_req),
    .agt_req(agt_req), .agt_cmd(agt_cmd), .agt_ack(agt_ack),
    .mem_restore_req(mem_restore_req), .mem_restore_done(mem_restore_done),
    .ctr_reset(ctr_reset), .io_isolate(io_isolate), .mode(mode), .dom_count(dom_count)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    failures++;
    $display("FAIL watchdog requirement=any actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic chk(string rq, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic clear_obs();
    n_rst = 0; rp_cycles = 0; order_err = 0; stop_exp = -1; save_cycles = 0;
    seen_ck = 0; seen_prep = 0; seen_save = 0; seen_rest = 0; seen_mem = 0;
    rst_seen_rp = 0; prep_ok = '0; save_ok = '0; rest_ok = '0;
  endtask

  // one clock: observe just after the edge, then set agent and memory answers
  task automatic tick();
    @(posedge clk);
    #1;
    if (ctr_reset) n_rst++;
    if (mode == 2'd1) seen_ck = 1;
    if (mode == 2'd2 && last_mode == 2'd0) stop_exp = int'(last_cnt);
    if (mode == 2'd2 && !ctr_reset && rst_seen_rp) rp_cycles++;
    if (ctr_reset && mode == 2'd2) rst_seen_rp = 1;
    if (agt_cmd == 2'd1) seen_prep = 1;
    if (agt_cmd == 2'd2) begin seen_save = 1; save_cycles++; end
    if (agt_cmd == 2'd3) seen_rest = 1;
    if (mem_restore_req) seen_mem = 1;
    if (agt_cmd == 2'd2 && prep_ok != '1) order_err++;
    if (mem_restore_req && rest_ok != '1) order_err++;
    if (ctr_reset && mode == 2'd1 && save_ok != '1) order_err++;
    for (int i = 0; i < NA; i++) begin
      if (agt_ack[i]) begin
        agt_ack[i] = 1'b0;
      end else if (agt_req[i] && !(sil_mask[i] && agt_cmd == sil_cmd)) begin
        if (acnt[i] >= dly[i]) begin
          agt_ack[i] = 1'b1;
          acnt[i] = 0;
          if (agt_cmd == 2'd1) prep_ok[i] = 1'b1;
          if (agt_cmd == 2'd2) save_ok[i] = 1'b1;
          if (agt_cmd == 2'd3) rest_ok[i] = 1'b1;
        end else begin
          acnt[i]++;
        end
      end else begin
        acnt[i] = 0;
      end
    end
    if (mem_restore_done) mem_restore_done = 1'b0;
    else if (mem_restore_req) begin
      if (mcnt >= 2) begin mem_restore_done = 1'b1; mcnt = 0; end
      else mcnt++;
    end
    last_mode = mode;
    last_cnt  = dom_count;
  endtask

  task automatic wait_normal();
    for (int k = 0; k < 600; k++) begin
      if (mode == 2'd0 && n_rst >= 1 && !ctr_reset) break;
      tick();
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    agt_ack = '0; mem_restore_done = 1'b0; mcnt = 0;
    for (int i = 0; i < NA; i++) acnt[i] = 0;
    repeat (3) tick();
  endtask

  initial begin
    log_near_full = '0; replay_req = 1'b0; sil_mask = '0; sil_cmd = 2'd0;
    last_mode = 2'd0; last_cnt = '0;
    for (int i = 0; i < NA; i++) dly[i] = 0;
    clear_obs();

    // R1: reset state
    do_reset();
    chk("R1 mode in reset", mode == 2'd0, mode, 0);
    chk("R1 outputs quiet in reset",
        agt_req == '0 && agt_cmd == 2'd0 && !ctr_reset && !io_isolate && !mem_restore_req,
        {agt_req, agt_cmd, ctr_reset, io_isolate, mem_restore_req}, 0);
    chk("R1 count zero in reset", dom_count == '0, dom_count, 0);
    rst_n = 1'b1;
    tick();
    chk("R1 count runs after release", dom_count == 16'd1, dom_count, 1);

    // vector table: each trigger kind with skewed answer delays
    for (int v = 0; v < 6; v++) begin
      int kind;
      kind = int'(VEC[v][18:16]);
      for (int i = 0; i < NA; i++) dly[i] = int'(VEC[v][4*i +: 4]);
      clear_obs();
      repeat (3) tick();
      if (kind == 3) replay_req = 1'b1;
      else if (kind == 4) log_near_full = '1;
      else log_near_full = NL'(1) << kind;
      tick();
      log_near_full = '0;
      replay_req = 1'b0;
      if (kind == 3) begin
        chk("R6 replay mode next clock", mode == 2'd2, mode, 2);
        chk("R8 io isolated in replay", io_isolate == 1'b1, io_isolate, 1);
        wait_normal();
        chk("R6 restore phase issued", seen_rest, seen_rest, 1);
        chk("R7 memory restore after all restore answers",
            seen_mem && order_err == 0, order_err, 0);
        chk("R7 single counter reset", n_rst == 1, n_rst, 1);
        chk("R8 replay length", rp_cycles == stop_exp + 1, rp_cycles, stop_exp + 1);
        chk("R8 count at replay end", int'(dom_count) == stop_exp + 1, dom_count, stop_exp + 1);
        chk("R8 io reconnected", !io_isolate && mode == 2'd0, io_isolate, 0);
      end else begin
        chk("R2 checkpoint on log flag", mode == 2'd1, mode, 1);
        wait_normal();
        chk("R3 prepare phase seen", seen_prep, seen_prep, 1);
        chk("R4 barriers ordered", seen_save && order_err == 0, order_err, 0);
        chk("R5 single counter reset", n_rst == 1, n_rst, 1);
        chk("R5 count zero after checkpoint", dom_count == '0, dom_count, 0);
      end
    end

    // R2: interval expiry
    clear_obs();
    for (int k = 0; k < 400 && mode == 2'd0; k++) tick();
    chk("R2 interval trigger count", int'(dom_count) == IMAX + 1, dom_count, IMAX + 1);
    wait_normal();
    chk("R5 interval checkpoint completes", mode == 2'd0 && dom_count == '0, dom_count, 0);

    // R11: replay request during a checkpoint is held
    clear_obs();
    log_near_full = 3'b001;
    tick();
    log_near_full = '0;
    tick();
    replay_req = 1'b1;
    tick();
    replay_req = 1'b0;
    chk("R11 still in checkpoint", mode == 2'd1, mode, 1);
    wait_normal();
    clear_obs();
    tick();
    chk("R11 held replay starts", mode == 2'd2 && stop_exp == 0, stop_exp, 0);
    for (int k = 0; k < 200 && !(mode == 2'd0 && rst_seen_rp); k++) tick();
    chk("R11 replay of length one", rp_cycles == 1, rp_cycles, 1);

    // R12: triggers during replay are ignored
    repeat (30) tick();
    clear_obs();
    replay_req = 1'b1;
    tick();
    replay_req = 1'b0;
    for (int k = 0; k < 200 && !(rst_seen_rp && mode == 2'd2 && !ctr_reset); k++) tick();
    log_near_full = '1;
    replay_req = 1'b1;
    tick();
    log_near_full = '0;
    replay_req = 1'b0;
    for (int k = 0; k < 400 && mode != 2'd0; k++) tick();
    chk("R12 replay length unchanged", rp_cycles == stop_exp + 1, rp_cycles, stop_exp + 1);
    repeat (5) tick();
    chk("R12 no follow-up action", mode == 2'd0 && n_rst == 1, mode, 0);

    // R9 and R10: agent 3 answers prepare but never save
    clear_obs();
    sil_mask = 4'b1000; sil_cmd = 2'd2;
    log_near_full = 3'b100;
    tick();
    log_near_full = '0;
    for (int k = 0; k < 300 && mode != 2'd3; k++) tick();
    chk("R9 prepare answer not carried into save", seen_save && mode == 2'd3, mode, 3);
    chk("R10 timeout length", save_cycles == WLIM + 1, save_cycles, WLIM + 1);
    sil_mask = '0;
    repeat (20) tick();
    chk("R10 fault sticky", mode == 2'd3 && agt_req == '0, mode, 3);
    do_reset();
    rst_n = 1'b1;
    tick();
    chk("R1 reset leaves fault", mode == 2'd0 && dom_count == 16'd1, mode, 0);

    summary();
    $finish;
  end

endmodule